// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block holds, for one processor, the record of which preemption levels currently have an interrupt in service, and it derives the running priority from that record. The record is a set of bitmaps indexed by the quantised priority, not a stack. A physical context keeps two banks, one per interrupt group, and a virtual context keeps one single-word map. The virtual map uses a coarser quantisation, so all of its levels fit in 32 bits.

An activate strobe carries the group priority of the interrupt being taken, its group and a virtual flag. It sets one level bit and loads the running priority of that context directly. A drop strobe carries a group and a virtual flag. It removes the most urgent active level from the selected map, then rebuilds the running priority of that context from the lowest level still set. When no level is set, the running priority reads as the idle value 0x100.

Both request inputs are single-cycle strobes that finish in the cycle they are sampled. They are plain control pins with no ready signal and no back-pressure. Each running-priority output is registered and shows the result of a request after the clock edge that samples it.

Top module: `apt_tracker`

## Requirements
- R1: After reset both running-priority outputs read 0x100, and every bitmap is empty.
- R2: A physical activate (act_virt=0) loads run_prio_phys with act_prio after the sampling edge and leaves run_prio_virt unchanged. A virtual activate (act_virt=1) loads run_prio_virt with act_prio and leaves run_prio_phys unchanged.
- R3: A physical activate sets level act_prio>>1 in one bank. The bank is the group-1 bank when act_group=1 and the group-0 bank when act_group=0. Level L sits in word L/32 at bit L%32 of that bank.
- R4: A physical drop clears only the lowest set level of the bank that drop_group selects (1 for group 1, 0 for group 0), and leaves the other bank alone. A drop on an empty bank changes no bitmap.
- R5: After a physical drop, run_prio_phys equals (lowest level set in either bank)<<1, or 0x100 if neither bank has a level set.
- R6: A virtual activate sets level act_prio>>3 in the virtual map whatever the value of act_group. The physical banks are not touched.
- R7: A virtual drop clears the lowest set level of the virtual map, ignores drop_group and leaves the physical banks alone. run_prio_virt then equals (lowest level still set)<<3, or 0x100 if the map is empty.
- R8: When act_valid and drop_valid are both high in the same cycle, the activate is performed and the drop is ignored.
- R9: Priorities that map to the same level share one bit, so a single drop removes all of them.
- R10: A running priority rebuilt after a drop is rounded down to its level boundary. This includes the highest level (127), which sits in the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate strobe |
| act_prio | input | 8 | Group priority of the interrupt being activated |
| act_group | input | 1 | Group of the activated interrupt (1 = group 1) |
| act_virt | input | 1 | Activate is for the virtual context |
| drop_valid | input | 1 | Priority-drop strobe |
| drop_group | input | 1 | Bank to drop from (1 = group 1), physical only |
| drop_virt | input | 1 | Drop is for the virtual context |
| run_prio_phys | output | 9 | Running priority of the physical context, 0x100 when idle |
| run_prio_virt | output | 9 | Running priority of the virtual context, 0x100 when idle |

## Verification
The bench aims at the bank choice on a drop. It activates into both banks, then drops group 0 twice and group 1 once. A design that cleared from the combined map, or from the wrong bank, would return the wrong level or would not return the idle value at the end.

Other cases target specific faults:
- Activate and drop in the same cycle, followed by a plain drop. This exposes a design that let the drop go through, because it would then lose the wrong level.
- Priorities that share a level. A design that quantised them wrongly would need two drops to empty the map.
- The level in the last word. A design that rebuilt the running priority without rounding it would report an odd value or a value off by a word.
- Drops that cross contexts. A design that shared state between the two contexts would disturb the other context's output.

// File: rtl/apt_pkg.sv
package apt_pkg;
  // Group encoding on act_group / drop_group.
  typedef enum logic {
    GRP_ZERO = 1'b0,
    GRP_ONE  = 1'b1
  } apt_group_e;

  localparam int APT_NUM_BANKS = 2;
endpackage

// File: rtl/apt_lsb_find.sv
module apt_lsb_find #(
  parameter int W     = 128,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/apt_level_map.sv
module apt_level_map #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int LVL_W  = 7,
  localparam int BITS   = WORDS * WORD_W,
  localparam int WIDX_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             clr_en,
  output logic [BITS-1:0]  map_nxt
);
  logic [WIDX_W-1:0] bit_sel;
  logic [LVL_W-1:0]  word_sel;
  logic [WORDS:0]    below_empty;

  assign bit_sel = set_lvl[WIDX_W-1:0];

  generate
    if (LVL_W > WIDX_W) begin : g_multi
      assign word_sel = LVL_W'(set_lvl[LVL_W-1:WIDX_W]);
    end else begin : g_single
      assign word_sel = '0;
    end
  endgenerate

  assign below_empty[0] = 1'b1;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    assign below_empty[w+1] = below_empty[w] & (word_q == '0);

    always_comb begin
      word_d = word_q;
      if (clr_en && below_empty[w] && (word_q != '0))
        word_d = word_q & (word_q - WORD_W'(1));
      if (set_en && (word_sel == LVL_W'(w)))
        word_d = word_d | (WORD_W'(1) << bit_sel);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign map_nxt[w*WORD_W +: WORD_W] = word_d;
  end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker #(
  parameter int PRIO_W       = 8,
  parameter int PHYS_MIN_BPR = 0,
  parameter int VIRT_MIN_BPR = 2,
  parameter int WORD_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [PRIO_W-1:0] act_prio,
  input  logic              act_group,
  input  logic              act_virt,
  input  logic              drop_valid,
  input  logic              drop_group,
  input  logic              drop_virt,
  output logic [PRIO_W:0]   run_prio_phys,
  output logic [PRIO_W:0]   run_prio_virt
);
  import apt_pkg::*;

  localparam int RUN_W   = PRIO_W + 1;
  localparam int PLVL_W  = PRIO_W - PHYS_MIN_BPR - 1;
  localparam int VLVL_W  = PRIO_W - VIRT_MIN_BPR - 1;
  localparam int PWORDS  = ((1 << PLVL_W) + WORD_W - 1) / WORD_W;
  localparam int VWORDS  = ((1 << VLVL_W) + WORD_W - 1) / WORD_W;
  localparam int PBITS   = PWORDS * WORD_W;
  localparam int VBITS   = VWORDS * WORD_W;
  localparam int PIDX_W  = $clog2(PBITS);
  localparam int VIDX_W  = $clog2(VBITS);
  localparam logic [RUN_W-1:0] RUN_IDLE = RUN_W'(1) << PRIO_W;

  logic [PLVL_W-1:0] lvl_phys;
  logic [VLVL_W-1:0] lvl_virt;
  logic              drop_ok;
  logic [PBITS-1:0]  bank_nxt [APT_NUM_BANKS];
  logic [PBITS-1:0]  union_nxt;
  logic [VBITS-1:0]  vmap_nxt;
  logic              p_found, v_found;
  logic [PIDX_W-1:0] p_idx;
  logic [VIDX_W-1:0] v_idx;

  assign lvl_phys = PLVL_W'(act_prio >> (PHYS_MIN_BPR + 1));
  assign lvl_virt = VLVL_W'(act_prio >> (VIRT_MIN_BPR + 1));
  // An activate in the same cycle wins over a drop.
  assign drop_ok  = drop_valid & ~act_valid;

  for (genvar g = 0; g < APT_NUM_BANKS; g++) begin : g_bank
    apt_level_map #(
      .WORDS (PWORDS),
      .WORD_W(WORD_W),
      .LVL_W (PLVL_W)
    ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (act_valid & ~act_virt & (act_group == apt_group_e'(g))),
      .set_lvl(lvl_phys),
      .clr_en (drop_ok & ~drop_virt & (drop_group == apt_group_e'(g))),
      .map_nxt(bank_nxt[g])
    );
  end

  apt_level_map #(
    .WORDS (VWORDS),
    .WORD_W(WORD_W),
    .LVL_W (VLVL_W)
  ) vmap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (act_valid & act_virt),
    .set_lvl(lvl_virt),
    .clr_en (drop_ok & drop_virt),
    .map_nxt(vmap_nxt)
  );

  assign union_nxt = bank_nxt[0] | bank_nxt[1];

  apt_lsb_find #(.W(PBITS)) p_find_i (
    .vec  (union_nxt),
    .found(p_found),
    .idx  (p_idx)
  );

  apt_lsb_find #(.W(VBITS)) v_find_i (
    .vec  (vmap_nxt),
    .found(v_found),
    .idx  (v_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_prio_phys <= RUN_IDLE;
      run_prio_virt <= RUN_IDLE;
    end else begin
      if (act_valid && !act_virt)
        run_prio_phys <= RUN_W'(act_prio);
      else if (drop_ok && !drop_virt)
        run_prio_phys <= p_found ? (RUN_W'(p_idx) << (PHYS_MIN_BPR + 1)) : RUN_IDLE;

      if (act_valid && act_virt)
        run_prio_virt <= RUN_W'(act_prio);
      else if (drop_ok && drop_virt)
        run_prio_virt <= v_found ? (RUN_W'(v_idx) << (VIRT_MIN_BPR + 1)) : RUN_IDLE;
    end
  end
endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
  parameter int PRIO_W       = 8,
  parameter int PHYS_MIN_BPR = 0,
  parameter int VIRT_MIN_BPR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_valid,
  input logic [PRIO_W-1:0] act_prio,
  input logic              act_group,
  input logic              act_virt,
  input logic              drop_valid,
  input logic              drop_group,
  input logic              drop_virt,
  input logic [PRIO_W:0]   run_prio_phys,
  input logic [PRIO_W:0]   run_prio_virt
);
  localparam logic [PRIO_W:0] PMASK = (PRIO_W+1)'((1 << (PHYS_MIN_BPR + 1)) - 1);
  localparam logic [PRIO_W:0] VMASK = (PRIO_W+1)'((1 << (VIRT_MIN_BPR + 1)) - 1);

  // R1: an idle reading never carries low priority bits
  a_r1_idle_form: assert property (@(posedge clk) disable iff (!rst_n)
    run_prio_phys[PRIO_W] |-> (run_prio_phys[PRIO_W-1:0] == '0));

  // R2: physical activate loads the physical running priority
  a_r2_phys_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_virt) |=> (run_prio_phys == {1'b0, $past(act_prio)}));

  // R2: virtual activate loads the virtual running priority
  a_r2_virt_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_virt) |=> (run_prio_virt == {1'b0, $past(act_prio)}));

  // R6: a virtual activate leaves the physical context alone
  a_r6_phys_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_virt) |=> $stable(run_prio_phys));

  // R7: a physical request leaves the virtual context alone
  a_r7_virt_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_valid && !act_virt) || (drop_valid && !drop_virt && !act_valid))
      |=> $stable(run_prio_virt));

  // R5: a rebuilt physical priority is on a level boundary
  a_r5_phys_grain: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && !drop_virt && !act_valid) |=> ((run_prio_phys & PMASK) == '0));

  // R7: a rebuilt virtual priority is on a level boundary
  a_r7_virt_grain: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && drop_virt && !act_valid) |=> ((run_prio_virt & VMASK) == '0));

  // R4: with no request both outputs hold
  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && !drop_valid) |=> ($stable(run_prio_phys) && $stable(run_prio_virt)));

  // R8: an activate alongside a drop still loads the priority
  a_r8_act_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && drop_valid && !act_virt) |=> (run_prio_phys == {1'b0, $past(act_prio)}));
endmodule

bind apt_tracker apt_tracker_chk #(
  .PRIO_W      (PRIO_W),
  .PHYS_MIN_BPR(PHYS_MIN_BPR),
  .VIRT_MIN_BPR(VIRT_MIN_BPR)
) chk_i (.*);

// File: tb/apt_tracker_tb_top.sv
`timescale 1ns/1ps
module apt_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_valid = 1'b0;
  logic [7:0] act_prio = '0;
  logic       act_group = 1'b0;
  logic       act_virt = 1'b0;
  logic       drop_valid = 1'b0;
  logic       drop_group = 1'b0;
  logic       drop_virt = 1'b0;
  logic [8:0] run_prio_phys;
  logic [8:0] run_prio_virt;

  always #5 clk = ~clk;

  apt_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .act_valid(act_valid), .act_prio(act_prio), .act_group(act_group), .act_virt(act_virt),
    .drop_valid(drop_valid), .drop_group(drop_group), .drop_virt(drop_virt),
    .run_prio_phys(run_prio_phys), .run_prio_virt(run_prio_virt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference state built from the requirements.
  bit [127:0] m_g0, m_g1;
  bit [31:0]  m_v;
  logic [8:0] e_phys = 9'h100;
  logic [8:0] e_virt = 9'h100;

  int         q_due[$];
  logic [8:0] q_phys[$];
  logic [8:0] q_virt[$];
  string      q_tag[$];

  function automatic int lowest128(bit [127:0] v);
    for (int i = 0; i < 128; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int lowest32(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit a, bit [7:0] pr, bit ag, bit av,
                    bit d, bit dg, bit dv, string tag);
    int k;
    @(negedge clk);
    act_valid = a; act_prio = pr; act_group = ag; act_virt = av;
    drop_valid = d; drop_group = dg; drop_virt = dv;
    if (a) begin
      if (av) begin m_v[pr >> 3] = 1'b1; e_virt = {1'b0, pr}; end
      else begin
        if (ag) m_g1[pr >> 1] = 1'b1; else m_g0[pr >> 1] = 1'b1;
        e_phys = {1'b0, pr};
      end
    end else if (d) begin
      if (dv) begin
        k = lowest32(m_v);
        if (k >= 0) m_v[k] = 1'b0;
        k = lowest32(m_v);
        e_virt = (k >= 0) ? 9'(k * 8) : 9'h100;
      end else begin
        if (dg) begin k = lowest128(m_g1); if (k >= 0) m_g1[k] = 1'b0; end
        else    begin k = lowest128(m_g0); if (k >= 0) m_g0[k] = 1'b0; end
        k = lowest128(m_g0 | m_g1);
        e_phys = (k >= 0) ? 9'(k * 2) : 9'h100;
      end
    end
    q_due.push_back(cyc + 1);
    q_phys.push_back(e_phys);
    q_virt.push_back(e_virt);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    act_valid = 1'b0; drop_valid = 1'b0;
  endtask

  // Monitor: compare queued expectations when they fall due.
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      check({q_tag[0], " phys"}, run_prio_phys, q_phys[0]);
      check({q_tag[0], " virt"}, run_prio_virt, q_virt[0]);
      void'(q_due.pop_front()); void'(q_phys.pop_front());
      void'(q_virt.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset phys", run_prio_phys, 9'h100);
    check("R1 reset virt", run_prio_virt, 9'h100);

    // Banking and drop per group
    op(1, 8'h10, 1, 0, 0, 0, 0, "R2 R3 act g1 0x10");
    op(1, 8'h20, 0, 0, 0, 0, 0, "R3 act g0 0x20");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R4 R5 drop g0");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R4 drop empty g0");
    op(0, 8'h00, 0, 0, 1, 1, 0, "R5 drop g1 to idle");
    // Virtual context
    op(1, 8'h4D, 1, 1, 0, 0, 0, "R2 R6 virt act 0x4D");
    op(1, 8'h01, 0, 1, 0, 0, 0, "R6 virt act 0x01");
    op(0, 8'h00, 0, 0, 1, 0, 1, "R7 R10 virt drop");
    op(0, 8'h00, 0, 0, 1, 1, 1, "R7 virt drop to idle");
    op(0, 8'h00, 0, 0, 1, 0, 1, "R7 virt drop empty");
    // Shared level
    op(1, 8'h20, 0, 0, 0, 0, 0, "R9 act 0x20");
    op(1, 8'h21, 0, 0, 0, 0, 0, "R9 act 0x21");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R9 one drop empties");
    // Quantisation and the last word
    op(1, 8'hFF, 1, 0, 0, 0, 0, "R10 act 0xFF");
    op(1, 8'h31, 1, 0, 0, 0, 0, "R10 act 0x31");
    op(1, 8'h05, 1, 0, 0, 0, 0, "R10 act 0x05");
    op(0, 8'h00, 0, 0, 1, 1, 0, "R10 drop to 0x30");
    op(0, 8'h00, 0, 0, 1, 1, 0, "R10 drop to 0xFE");
    op(0, 8'h00, 0, 0, 1, 1, 0, "R10 drop to idle");
    // Activate and drop together
    op(1, 8'h10, 0, 0, 0, 0, 0, "R8 act 0x10");
    op(1, 8'h40, 0, 0, 1, 0, 0, "R8 act 0x40 with drop");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R8 drop keeps 0x40");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R8 drop to idle");
    // Group ignored for virtual; cross-context drops
    op(1, 8'h80, 0, 1, 0, 0, 0, "R6 virt act g0 0x80");
    op(1, 8'h20, 1, 1, 0, 0, 0, "R6 virt act g1 0x20");
    op(0, 8'h00, 0, 0, 1, 0, 1, "R7 virt drop group ignored");
    op(1, 8'h60, 0, 0, 0, 0, 0, "R2 phys act 0x60");
    op(0, 8'h00, 0, 0, 1, 1, 1, "R7 virt drop leaves phys");
    op(0, 8'h00, 0, 0, 1, 0, 0, "R4 phys drop leaves virt");
    idle();
    repeat (4) @(negedge clk);
    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d expectations unchecked, expected 0", q_due.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule